// File: doc/BRIEF.md
# Chained DMA Channel Register Engine

This block is the register and sequencing core of one DMA channel. Software programs it over a small 32-bit register port. The port has a control/status word, a start address and a byte count. The engine then raises a transfer request that carries the direction and the burst length. It also presents the address that the bus master should use next. A separate bus master, which is not part of this block, reports each finished data beat on a progress input, along with the number of bytes that beat moved. The engine advances its address, counts the bytes down and flags terminal count. It can also raise an interrupt.

The address and count offsets are shared by two register pairs, a current pair and a shadow pair. A control bit picks which pair a write lands in. While the current transfer runs, software can queue the next one in the shadow pair. At terminal count the engine copies the shadow into the current pair and keeps going with no gap. When no shadow is queued, the channel goes idle.

Top module: `dmac_chain`

## Requirements
- R1: After reset, offset 0 reads 0xC0000000, offsets 4 and 8 read 0, and req_valid is low.
- R2: With control bit 24 clear, writes to offset 4 and offset 8 load the current address and the current count. Both read back at those offsets, and the offset-4 write sets status bit 26.
- R3: With control bit 24 set, writes to offsets 4 and 8 load the shadow pair instead. Offsets 4 and 8 keep showing the current pair, and the offset-4 write sets status bit 27.
- R4: Each beat accepted while req_valid is high adds beat_bytes to the address. When bit 13 is set, it also subtracts beat_bytes from the count. When bit 13 is clear, the count stays unchanged and terminal count never occurs.
- R5: When a beat takes the count to zero or below it, the count becomes 0 and bit 14 sets. Writing 1 to bit 14 clears it.
- R6: At terminal count with bits 24 and 13 set and bit 27 set, the shadow address and count move into the current pair. Bit 27 clears, bit 26 stays set, and requests continue.
- R7: At terminal count with no shadow queued, bit 26 and bit 25 clear and req_valid drops.
- R8: Terminal count sets bit 0 when bit 4 is set and bit 23 is clear. The irq output equals bit 0, and writing 1 to bit 0 clears it.
- R9: req_valid is high only when bit 9 is set, bit 26 is set, bit 7 is clear and no stopping error is pending. req_dir equals bit 8. req_words follows bits 19:18, with 00 giving 4, 01 giving 8, 10 giving 1 and 11 giving 16.
- R10: Bit 10 reads back the current value of req_valid.
- R11: Bit 7 stays set until software writes 0 to it. While it is set, req_valid is low, the current pair and both loaded flags are held at zero, and writes to offsets 4 and 8 are ignored.
- R12: A pulse on err_in sets bit 1, which is cleared by writing 1 to it. With bit 22 clear, the pulse stops requests and sets bit 0 if bit 4 is set. With bit 22 set, requests continue and no interrupt is raised.
- R13: Bits 31:28 always read 0xC. Bits 10 and 25 to 28 ignore writes, and unused bits such as 3 and 16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 4 | Byte offset: 0, 4 or 8 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_off, combinational |
| beat_done | input | 1 | A data beat has completed |
| beat_bytes | input | BEAT_W | Number of bytes moved by the completed beat |
| err_in | input | 1 | Transfer error pulse |
| req_valid | output | 1 | Transfer request |
| req_dir | output | 1 | 0 means memory to device, 1 means device to memory |
| req_words | output | 5 | Burst length in words |
| req_addr | output | 32 | Current transfer address |
| irq | output | 1 | Interrupt request |

## Verification
The main counting path is driven with a series of beats of different sizes (4, 8, 1, 16, 64 and 7 bytes). The last beat lands exactly on zero, which separates a correct subtraction from a terminal count that fires one beat too early or too late. The chained case queues a shadow pair during an active transfer and checks the handover. It then lets a second terminal count hit with nothing queued, which separates the reload path from the stop path. Error pulses are applied with and without the stop-disable bit, beats are applied with the counter disabled, and software reset is held while writes arrive. These runs separate the gating conditions on req_valid from one another.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int B_INT    = 0;
  localparam int B_ERR    = 1;
  localparam int B_IEN    = 4;
  localparam int B_SRST   = 7;
  localparam int B_DIR    = 8;
  localparam int B_EN     = 9;
  localparam int B_CYC    = 10;
  localparam int B_CNTEN  = 13;
  localparam int B_TC     = 14;
  localparam int B_BL     = 18;
  localparam int B_DISERR = 22;
  localparam int B_TCIDIS = 23;
  localparam int B_NEXT   = 24;
  localparam int B_ON     = 25;
  localparam int B_AL     = 26;
  localparam int B_NAL    = 27;
  localparam logic [3:0] DEV_ID = 4'hC;

  typedef struct packed {
    logic       en_next;
    logic       tci_dis;
    logic       dis_err;
    logic [1:0] burst;
    logic       tc;
    logic       en_cnt;
    logic       en_dma;
    logic       dir;
    logic       srst;
    logic       int_en;
    logic       err_pend;
    logic       int_pend;
  } ctrl_t;

  function automatic logic [4:0] burst_words(input logic [1:0] code);
    case (code)
      2'b00:   burst_words = 5'd4;
      2'b01:   burst_words = 5'd8;
      2'b10:   burst_words = 5'd1;
      default: burst_words = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        tc_evt,
  input  logic        err_evt,
  output ctrl_t       ctrl
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;
  logic  unused_wdata;

  assign unused_wdata = ^{wdata[31:25], wdata[21:20], wdata[17:15],
                          wdata[12:10], wdata[6:5], wdata[3:2]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d.int_en  = wdata[B_IEN];
      ctrl_d.srst    = wdata[B_SRST];
      ctrl_d.dir     = wdata[B_DIR];
      ctrl_d.en_dma  = wdata[B_EN];
      ctrl_d.en_cnt  = wdata[B_CNTEN];
      ctrl_d.burst   = wdata[B_BL+1:B_BL];
      ctrl_d.dis_err = wdata[B_DISERR];
      ctrl_d.tci_dis = wdata[B_TCIDIS];
      ctrl_d.en_next = wdata[B_NEXT];
      if (wdata[B_INT]) ctrl_d.int_pend = 1'b0;
      if (wdata[B_ERR]) ctrl_d.err_pend = 1'b0;
      if (wdata[B_TC])  ctrl_d.tc       = 1'b0;
    end
    if (tc_evt) begin
      ctrl_d.tc = 1'b1;
      if (ctrl_q.int_en && !ctrl_q.tci_dis) ctrl_d.int_pend = 1'b1;
    end
    if (err_evt) begin
      ctrl_d.err_pend = 1'b1;
      if (ctrl_q.int_en && !ctrl_q.dis_err) ctrl_d.int_pend = 1'b1;
    end
  end

  assign ctrl_en = wr | tc_evt | err_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/dmac_ptr.sv
module dmac_ptr #(
  parameter int AW     = 32,
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [AW-1:0]     wdata,
  input  logic              en_next,
  input  logic              en_cnt,
  input  logic              srst,
  input  logic              beat,
  input  logic [BEAT_W-1:0] beat_bytes,
  output logic [AW-1:0]     cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [AW-1:0]     nxt_addr,
  output logic              a_loaded,
  output logic              na_loaded,
  output logic              tc_evt
);
  localparam int APAD = AW - BEAT_W;
  localparam int CPAD = CNT_W - BEAT_W;

  logic [AW-1:0]    addr_q, addr_d, naddr_q, naddr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ncnt_q, ncnt_d;
  logic             al_q, al_d, nal_q, nal_d;
  logic [AW-1:0]    step_a;
  logic [CNT_W-1:0] step_c;
  logic             hit, upd;

  assign step_a = {{APAD{1'b0}}, beat_bytes};
  assign step_c = {{CPAD{1'b0}}, beat_bytes};
  assign hit    = (cnt_q <= step_c);

  always_comb begin
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    naddr_d = naddr_q;
    ncnt_d  = ncnt_q;
    al_d    = al_q;
    nal_d   = nal_q;
    tc_evt  = 1'b0;
    if (srst) begin
      addr_d  = '0;
      cnt_d   = '0;
      naddr_d = '0;
      ncnt_d  = '0;
      al_d    = 1'b0;
      nal_d   = 1'b0;
    end else begin
      if (beat) begin
        addr_d = addr_q + step_a;
        if (en_cnt) begin
          cnt_d = hit ? '0 : cnt_q - step_c;
          if (hit) begin
            tc_evt = 1'b1;
            if (en_next && nal_q) begin
              addr_d = naddr_q;
              cnt_d  = ncnt_q;
              nal_d  = 1'b0;
            end else begin
              al_d = 1'b0;
            end
          end
        end
      end
      if (wr_addr) begin
        if (en_next) begin
          naddr_d = wdata;
          nal_d   = 1'b1;
        end else begin
          addr_d = wdata;
          al_d   = 1'b1;
        end
      end
      if (wr_cnt) begin
        if (en_next) ncnt_d = wdata[CNT_W-1:0];
        else         cnt_d  = wdata[CNT_W-1:0];
      end
    end
  end

  assign upd = srst | beat | wr_addr | wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      naddr_q <= '0;
      ncnt_q  <= '0;
      al_q    <= 1'b0;
      nal_q   <= 1'b0;
    end else if (upd) begin
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      naddr_q <= naddr_d;
      ncnt_q  <= ncnt_d;
      al_q    <= al_d;
      nal_q   <= nal_d;
    end
  end

  assign cur_addr  = addr_q;
  assign cur_cnt   = cnt_q;
  assign nxt_addr  = naddr_q;
  assign a_loaded  = al_q;
  assign na_loaded = nal_q;
endmodule

// File: rtl/dmac_req.sv
module dmac_req
  import dmac_pkg::*;
(
  input  ctrl_t      ctrl,
  input  logic       a_loaded,
  output logic       dma_on,
  output logic       req_valid,
  output logic       req_dir,
  output logic [4:0] req_words
);
  logic err_stop;

  assign err_stop  = ctrl.err_pend & ~ctrl.dis_err;
  assign dma_on    = ctrl.en_dma & ~ctrl.srst & a_loaded & ~err_stop;
  assign req_valid = dma_on;
  assign req_dir   = ctrl.dir;
  assign req_words = burst_words(ctrl.burst);
endmodule

// File: rtl/dmac_chain.sv
module dmac_chain
  import dmac_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_off,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              beat_done,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              err_in,
  output logic              req_valid,
  output logic              req_dir,
  output logic [4:0]        req_words,
  output logic [31:0]       req_addr,
  output logic              irq
);
  localparam int AW = 32;

  logic             srst_n;
  ctrl_t            ctrl;
  logic             wr_csr, wr_addr, wr_cnt;
  logic             beat, err_evt, tc_evt, dma_on;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic [CNT_W-1:0] cur_cnt;
  logic             a_loaded, na_loaded;
  logic [31:0]      csr_word;

  dmac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign wr_csr  = reg_wr && (reg_off == 4'd0);
  assign wr_addr = reg_wr && (reg_off == 4'd4);
  assign wr_cnt  = reg_wr && (reg_off == 4'd8);
  assign beat    = beat_done & dma_on;
  assign err_evt = err_in & ~ctrl.srst;

  dmac_csr u_csr (
    .clk(clk), .rst_n(srst_n), .wr(wr_csr), .wdata(reg_wdata),
    .tc_evt(tc_evt), .err_evt(err_evt), .ctrl(ctrl)
  );

  dmac_ptr #(.AW(AW), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_ptr (
    .clk(clk), .rst_n(srst_n), .wr_addr(wr_addr), .wr_cnt(wr_cnt),
    .wdata(reg_wdata), .en_next(ctrl.en_next), .en_cnt(ctrl.en_cnt),
    .srst(ctrl.srst), .beat(beat), .beat_bytes(beat_bytes),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .nxt_addr(nxt_addr),
    .a_loaded(a_loaded), .na_loaded(na_loaded), .tc_evt(tc_evt)
  );

  dmac_req u_req (
    .ctrl(ctrl), .a_loaded(a_loaded), .dma_on(dma_on),
    .req_valid(req_valid), .req_dir(req_dir), .req_words(req_words)
  );

  always_comb begin
    csr_word                = '0;
    csr_word[B_INT]         = ctrl.int_pend;
    csr_word[B_ERR]         = ctrl.err_pend;
    csr_word[B_IEN]         = ctrl.int_en;
    csr_word[B_SRST]        = ctrl.srst;
    csr_word[B_DIR]         = ctrl.dir;
    csr_word[B_EN]          = ctrl.en_dma;
    csr_word[B_CYC]         = req_valid;
    csr_word[B_CNTEN]       = ctrl.en_cnt;
    csr_word[B_TC]          = ctrl.tc;
    csr_word[B_BL+1:B_BL]   = ctrl.burst;
    csr_word[B_DISERR]      = ctrl.dis_err;
    csr_word[B_TCIDIS]      = ctrl.tci_dis;
    csr_word[B_NEXT]        = ctrl.en_next;
    csr_word[B_ON]          = dma_on;
    csr_word[B_AL]          = a_loaded;
    csr_word[B_NAL]         = na_loaded;
    csr_word[31:28]         = DEV_ID;
  end

  always_comb begin
    case (reg_off)
      4'd0:    reg_rdata = csr_word;
      4'd4:    reg_rdata = cur_addr;
      4'd8:    reg_rdata = {{(32-CNT_W){1'b0}}, cur_cnt};
      default: reg_rdata = '0;
    endcase
  end

  assign req_addr = cur_addr;
  assign irq      = ctrl.int_pend;
endmodule

// File: rtl/dmac_chain_chk.sv
module dmac_chain_chk #(
  parameter int CNT_W  = 24,
  parameter int BEAT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_off,
  input logic [31:0]       reg_rdata,
  input logic              beat_done,
  input logic [BEAT_W-1:0] beat_bytes,
  input logic              err_in,
  input logic              req_valid,
  input logic              en_cnt,
  input logic              en_next,
  input logic              srst,
  input logic [31:0]       cur_addr,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [31:0]       nxt_addr,
  input logic              na_loaded
);
  logic [31:0]      step32;
  logic [CNT_W-1:0] stepc;
  logic             quiet_beat, last_beat;

  assign step32     = {{(32-BEAT_W){1'b0}}, beat_bytes};
  assign stepc      = {{(CNT_W-BEAT_W){1'b0}}, beat_bytes};
  assign quiet_beat = beat_done && req_valid && !reg_wr && !err_in;
  assign last_beat  = quiet_beat && en_cnt && (cur_cnt <= stepc);

  // R13
  id_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off == 4'd0) |-> (reg_rdata[31:28] == 4'hC));

  // R10
  cyc_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off == 4'd0) |-> (reg_rdata[10] == req_valid));

  // R11
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> !req_valid);

  // R11
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cur_addr == 32'd0 && cur_cnt == '0));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_beat && !(en_cnt && (cur_cnt <= stepc)))
      |=> (cur_addr == $past(cur_addr) + $past(step32)));

  // R6
  autoload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && en_next && na_loaded)
      |=> (req_valid && cur_addr == $past(nxt_addr)));

  // R7
  tc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !(en_next && na_loaded)) |=> !req_valid);
endmodule

bind dmac_chain dmac_chain_chk #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) chk (
  .clk(clk), .rst_n(srst_n), .reg_wr(reg_wr), .reg_off(reg_off),
  .reg_rdata(reg_rdata), .beat_done(beat_done), .beat_bytes(beat_bytes),
  .err_in(err_in), .req_valid(req_valid), .en_cnt(ctrl.en_cnt),
  .en_next(ctrl.en_next), .srst(ctrl.srst), .cur_addr(cur_addr),
  .cur_cnt(cur_cnt), .nxt_addr(nxt_addr), .na_loaded(na_loaded)
);

// File: tb/dmac_chain_test.sv
module dmac_chain_test;
  localparam int CNT_W  = 24;
  localparam int BEAT_W = 7;

  localparam logic [31:0] M_INT    = 32'h1 << 0;
  localparam logic [31:0] M_ERR    = 32'h1 << 1;
  localparam logic [31:0] M_IEN    = 32'h1 << 4;
  localparam logic [31:0] M_SRST   = 32'h1 << 7;
  localparam logic [31:0] M_DIR    = 32'h1 << 8;
  localparam logic [31:0] M_EN     = 32'h1 << 9;
  localparam logic [31:0] M_CNTEN  = 32'h1 << 13;
  localparam logic [31:0] M_TC     = 32'h1 << 14;
  localparam logic [31:0] M_DISERR = 32'h1 << 22;
  localparam logic [31:0] M_TCIDIS = 32'h1 << 23;
  localparam logic [31:0] M_NEXT   = 32'h1 << 24;
  localparam logic [31:0] CTL_BASE = M_EN | M_CNTEN | M_IEN | M_DIR;
  localparam logic [31:0] CTL_A    = CTL_BASE | (32'h1 << 18);

  localparam int NV = 6;
  localparam int unsigned TB_BEAT [NV] = '{4, 8, 1, 16, 64, 7};
  localparam int unsigned TB_ADDR [NV] = '{32'h1004, 32'h100C, 32'h100D,
                                           32'h101D, 32'h105D, 32'h1064};
  localparam int unsigned TB_CNT  [NV] = '{96, 88, 87, 71, 7, 0};
  localparam int unsigned WORDS   [4]  = '{4, 8, 1, 16};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [3:0]        reg_off = 4'd0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              beat_done = 1'b0;
  logic [BEAT_W-1:0] beat_bytes = '0;
  logic              err_in = 1'b0;
  logic              req_valid, req_dir, irq;
  logic [4:0]        req_words;
  logic [31:0]       req_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  dmac_chain #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_done(beat_done),
    .beat_bytes(beat_bytes), .err_in(err_in), .req_valid(req_valid),
    .req_dir(req_dir), .req_words(req_words), .req_addr(req_addr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [31:0] d);
    reg_off = off;
    #1;
    d = reg_rdata;
  endtask

  task automatic beat(input int unsigned n);
    @(negedge clk);
    beat_done = 1'b1; beat_bytes = BEAT_W'(n);
    @(negedge clk);
    beat_done = 1'b0;
  endtask

  task automatic err_pulse();
    @(negedge clk);
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 csr", v, 32'hC000_0000);
    rd(4, v); chk("R1 addr", v, 0);
    rd(8, v); chk("R1 cnt", v, 0);
    chk("R1 req_valid", {31'd0, req_valid}, 0);

    // R2 direct load; R9 gating before load
    wr(0, CTL_A);
    chk("R9 not loaded", {31'd0, req_valid}, 0);
    wr(4, 32'h1000);
    wr(8, 100);
    rd(0, v); chk("R2 a_loaded", {31'd0, v[26]}, 1);
    rd(4, v); chk("R2 addr", v, 32'h1000);
    rd(8, v); chk("R2 cnt", v, 100);
    chk("R9 req_valid", {31'd0, req_valid}, 1);
    chk("R9 dir", {31'd0, req_dir}, 1);
    chk("R9 words", {27'd0, req_words}, 8);
    rd(0, v); chk("R10 cyc_pend", {31'd0, v[10]}, 1);
    chk("R4 req_addr", req_addr, 32'h1000);

    // R4 table of beat sizes, last one lands on zero
    for (int i = 0; i < NV; i++) begin
      beat(TB_BEAT[i]);
      rd(4, v); chk("R4 addr step", v, TB_ADDR[i]);
      rd(8, v); chk("R4 cnt step", v, TB_CNT[i]);
    end
    rd(0, v);
    chk("R5 tc set", {31'd0, v[14]}, 1);
    chk("R8 int_pend", {31'd0, v[0]}, 1);
    chk("R8 irq", {31'd0, irq}, 1);
    chk("R7 a_loaded clear", {31'd0, v[26]}, 0);
    chk("R7 dma_on clear", {31'd0, v[25]}, 0);
    chk("R7 req_valid", {31'd0, req_valid}, 0);

    // R5 R8 R13 W1C and read-only bits
    wr(0, CTL_A | M_TC | M_INT | (32'h7 << 25) | (32'h1 << 10) | (32'h1 << 3) | (32'h1 << 16));
    rd(0, v); chk("R13 R5 R8 csr after w1c", v, CTL_A | 32'hC000_0000);
    chk("R8 irq cleared", {31'd0, irq}, 0);

    // R3 R6 chained reload
    wr(4, 32'h2000);
    wr(8, 8);
    wr(0, CTL_A | M_NEXT | M_TCIDIS);
    wr(4, 32'h3000);
    wr(8, 12);
    rd(4, v); chk("R3 cur addr kept", v, 32'h2000);
    rd(8, v); chk("R3 cur cnt kept", v, 8);
    rd(0, v); chk("R3 na_loaded", {31'd0, v[27]}, 1);
    beat(8);
    rd(4, v); chk("R6 addr reload", v, 32'h3000);
    rd(8, v); chk("R6 cnt reload", v, 12);
    rd(0, v);
    chk("R6 na_loaded clear", {31'd0, v[27]}, 0);
    chk("R6 a_loaded kept", {31'd0, v[26]}, 1);
    chk("R5 tc on reload", {31'd0, v[14]}, 1);
    chk("R6 req_valid", {31'd0, req_valid}, 1);
    chk("R8 tci_dis blocks irq", {31'd0, irq}, 0);
    beat(12);
    chk("R7 stop no shadow", {31'd0, req_valid}, 0);
    rd(4, v); chk("R7 addr", v, 32'h300C);
    wr(0, CTL_A | M_TC);

    // R9 burst encodings and direction
    for (int c = 0; c < 4; c++) begin
      wr(0, (CTL_BASE & ~M_DIR) | (32'(c) << 18));
      chk("R9 burst words", {27'd0, req_words}, WORDS[c]);
      chk("R9 dir zero", {31'd0, req_dir}, 0);
    end

    // R12 errors
    wr(0, CTL_A);
    wr(4, 32'h4000);
    wr(8, 50);
    chk("R12 running", {31'd0, req_valid}, 1);
    err_pulse();
    rd(0, v); chk("R12 err_pend", {31'd0, v[1]}, 1);
    chk("R12 stopped", {31'd0, req_valid}, 0);
    chk("R12 irq", {31'd0, irq}, 1);
    wr(0, CTL_A | M_ERR | M_INT);
    chk("R12 resumed", {31'd0, req_valid}, 1);
    chk("R12 irq cleared", {31'd0, irq}, 0);
    wr(0, CTL_A | M_DISERR);
    err_pulse();
    rd(0, v); chk("R12 err_pend no stop", {31'd0, v[1]}, 1);
    chk("R12 continues", {31'd0, req_valid}, 1);
    chk("R12 no irq", {31'd0, irq}, 0);

    // R4 counter disabled
    wr(0, (CTL_A & ~M_CNTEN) | M_DISERR | M_ERR);
    beat(60);
    rd(4, v); chk("R4 addr no cnt", v, 32'h403C);
    rd(8, v); chk("R4 cnt held", v, 50);
    rd(0, v); chk("R4 no tc", {31'd0, v[14]}, 0);

    // R11 software reset
    wr(0, CTL_A | M_SRST);
    chk("R11 req low", {31'd0, req_valid}, 0);
    @(negedge clk);
    rd(4, v); chk("R11 addr clear", v, 0);
    rd(8, v); chk("R11 cnt clear", v, 0);
    rd(0, v); chk("R11 loaded clear", {30'd0, v[27:26]}, 0);
    wr(4, 32'h5000);
    rd(4, v); chk("R11 write ignored", v, 0);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R11 bit stays", {31'd0, v[7]}, 1);
    wr(0, CTL_A);
    rd(0, v); chk("R11 bit cleared", {31'd0, v[7]}, 0);
    chk("R11 idle after", {31'd0, req_valid}, 0);

    finish_run();
  end
endmodule